// File: doc/BRIEF.md
# Master Clock Source Switcher

The block produces the master clock from one of four inputs: a slow low-power oscillator, a main crystal oscillator, and a PLL output running at one of two settings (A or B). Each PLL setting is its own clock input, so retuning the PLL is handled as a switch from one setting to the other. Software writes a source code on a port that is sampled on the slow clock. The block then turns the old source off and, after a fixed number of slow cycles that depends on the pair of sources, turns the new one on. The master clock stays low for the whole gap between the two.

Each source has a gating cell. Its enable changes only on that source's falling edge, so every high and low phase on the output is a whole half period of some source. A sequencer in the slow domain steps through the switch. It raises a busy flag while a switch is in progress, and it ignores any writes made during that time.

Top module: `mck_source_switch`

## Requirements
- R1: After reset the slow oscillator (code 0) drives the output, busy is low and the current-source output reads 0. Codes: 0 slow, 1 main, 2 PLL setting A, 3 PLL setting B.
- R2: A write naming a source other than the current one is accepted on a rising slow edge and sets busy from the next edge. Busy clears only after the new source drives the output, and the current-source output then reads the new code.
- R3: A write made while busy is ignored: the switch in progress completes to its original target and busy stays low afterwards.
- R4: A write naming the current source is ignored and busy stays low.
- R5: With the slow oscillator as destination, the first output rising edge from it falls exactly 5 slow periods after the accepting edge, whether the old source is main or PLL.
- R6: From the slow oscillator, the first new rising edge falls between N slow periods plus 2 and plus 3 periods of the new clock after the accepting edge. N is 3 into main and 4 into either PLL setting.
- R7: Main into PLL uses N = 5, and PLL into main uses N = 4, with the same window as R6.
- R8: PLL setting A into B, or B into A, uses N = 7 with the same window as R6.
- R9: No two sources are ever enabled at once, and the output makes no rising edge between the old source going quiet and the new source's first edge.
- R10: Every output high phase equals half the period of one source, and no output low phase is shorter than the shortest source half period.
- R11: Once a switch completes, the output period equals the new source's period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n_i | input | 1 | Asynchronous active-low reset, released per domain synchronously |
| slow_clk_i | input | 1 | Slow oscillator clock; also clocks the write port and sequencer |
| main_clk_i | input | 1 | Main oscillator clock |
| pll_a_clk_i | input | 1 | PLL output at setting A |
| pll_b_clk_i | input | 1 | PLL output at setting B |
| sel_we_i | input | 1 | Source selection write strobe (slow domain) |
| sel_src_i | input | 2 | Source code to select |
| mck_o | output | 1 | Master clock output |
| busy_o | output | 1 | High while a switch is in progress |
| cur_src_o | output | 2 | Code of the source currently driving the output |

## Verification
Suppose the drain counter loads the wrong count from the transition table. The first new rising edge then moves by at least one slow period, and the bench sees this on the first switch of that pair, measured against the accepting edge. Suppose instead a gating enable is sampled on the wrong edge, or two sources overlap. A high phase of the wrong width then appears on the output during that same handover. A sequencer that mishandles busy would either accept the stray write issued during a switch, which leaves the wrong current-source code once busy falls, or never clear busy. Both show within about ten slow cycles.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int N_SRC   = 4;
  localparam int LAT_MAX = 7;
  localparam int CNT_W   = $clog2(LAT_MAX + 1);

  typedef enum logic [1:0] {
    SRC_SLOW  = 2'd0,
    SRC_MAIN  = 2'd1,
    SRC_PLL_A = 2'd2,
    SRC_PLL_B = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_DRAIN  = 2'd1,
    SQ_LAUNCH = 2'd2
  } seq_e;

  // Slow-clock cycles between accepting a write and handing over.
  function automatic logic [CNT_W-1:0] drain_cycles(src_e from_s, src_e to_s);
    logic from_pll;
    logic to_pll;
    from_pll = from_s[1];
    to_pll   = to_s[1];
    if (from_pll && to_pll) return CNT_W'(7);
    case (to_s)
      SRC_SLOW: return CNT_W'(5);
      SRC_MAIN: return from_pll ? CNT_W'(4) : CNT_W'(3);
      default:  return (from_s == SRC_MAIN) ? CNT_W'(5) : CNT_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/mcs_reset_sync.sv
module mcs_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/mcs_gate_cell.sv
module mcs_gate_cell #(
  parameter int SYNC_STAGES = 2,
  parameter bit DIRECT      = 1'b0
) (
  input  logic src_clk_i,
  input  logic rst_n_i,
  input  logic on_req_i,
  output logic en_o,
  output logic gclk_o
);
  logic on_s;
  logic en_q;

  generate
    if (DIRECT) begin : g_direct
      // Request already lives in this clock's domain.
      assign on_s = on_req_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] req_q;
      always_ff @(posedge src_clk_i or negedge rst_n_i) begin
        if (!rst_n_i) req_q <= '0;
        else          req_q <= {req_q[SYNC_STAGES-2:0], on_req_i};
      end
      assign on_s = req_q[SYNC_STAGES-1];
    end
  endgenerate

  // Enable moves only while the source is low: no partial phases.
  always_ff @(negedge src_clk_i or negedge rst_n_i) begin
    if (!rst_n_i) en_q <= 1'b0;
    else          en_q <= on_s;
  end

  assign en_o   = en_q;
  assign gclk_o = src_clk_i & en_q;
endmodule

// File: rtl/mcs_sequencer.sv
module mcs_sequencer
  import mcs_pkg::*;
#(
  parameter int ACK_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             sel_we_i,
  input  logic [1:0]       sel_src_i,
  input  logic [N_SRC-1:0] ack_raw_i,
  output logic [N_SRC-1:0] on_req_o,
  output logic             busy_o,
  output logic [1:0]       cur_src_o
);
  seq_e             st_q, st_d;
  src_e             cur_q, cur_d;
  src_e             tgt_q, tgt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [N_SRC-1:0] on_q, on_d;
  logic [ACK_STAGES-1:0][N_SRC-1:0] ack_pipe_q;
  logic [N_SRC-1:0] ack_s;
  src_e             sel_src;
  logic             accept;
  logic [CNT_W-1:0] launch_at;

  assign sel_src = src_e'(sel_src_i);
  assign ack_s   = ack_pipe_q[ACK_STAGES-1];
  assign accept  = (st_q == SQ_IDLE) && sel_we_i && (sel_src != cur_q);
  // Slow destination launches one edge early: its own negedge enable
  // then lets the pulse on the counted edge through.
  assign launch_at = (tgt_q == SRC_SLOW) ? CNT_W'(1) : CNT_W'(0);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) ack_pipe_q <= '0;
    else          ack_pipe_q <= {ack_pipe_q[ACK_STAGES-2:0], ack_raw_i};
  end

  always_comb begin
    st_d  = st_q;
    cur_d = cur_q;
    tgt_d = tgt_q;
    cnt_d = cnt_q;
    on_d  = on_q;
    case (st_q)
      SQ_IDLE: begin
        if (accept) begin
          tgt_d       = sel_src;
          on_d[cur_q] = 1'b0;
          cnt_d       = drain_cycles(cur_q, sel_src) - CNT_W'(1);
          st_d        = SQ_DRAIN;
        end
      end
      SQ_DRAIN: begin
        if (cnt_q == launch_at) begin
          on_d[tgt_q] = 1'b1;
          st_d        = SQ_LAUNCH;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      SQ_LAUNCH: begin
        if (ack_s[tgt_q]) begin
          cur_d = tgt_q;
          st_d  = SQ_IDLE;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q  <= SQ_IDLE;
      cur_q <= SRC_SLOW;
      tgt_q <= SRC_SLOW;
      cnt_q <= '0;
      on_q  <= N_SRC'(1);
    end else begin
      st_q  <= st_d;
      cur_q <= cur_d;
      tgt_q <= tgt_d;
      cnt_q <= cnt_d;
      on_q  <= on_d;
    end
  end

  assign on_req_o  = on_q;
  assign busy_o    = (st_q != SQ_IDLE);
  assign cur_src_o = cur_q;

  assert_accept_sets_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ((st_q == SQ_IDLE) && sel_we_i && (sel_src != cur_q)) |=> busy_o);

  assert_done_updates_src_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(busy_o) |-> (cur_q == $past(tgt_q)));

  assert_busy_write_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (busy_o && sel_we_i) |=> $stable(tgt_q));

  assert_same_src_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ((st_q == SQ_IDLE) && sel_we_i && (sel_src == cur_q)) |=> !busy_o);

  assert_single_source_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ((st_q == SQ_LAUNCH) && ack_s[tgt_q]) |-> ($countones(ack_s) == 1));
endmodule

// File: rtl/mck_source_switch.sv
module mck_source_switch
  import mcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic       rst_n_i,
  input  logic       slow_clk_i,
  input  logic       main_clk_i,
  input  logic       pll_a_clk_i,
  input  logic       pll_b_clk_i,
  input  logic       sel_we_i,
  input  logic [1:0] sel_src_i,
  output logic       mck_o,
  output logic       busy_o,
  output logic [1:0] cur_src_o
);
  logic [N_SRC-1:0] src_clk;
  logic [N_SRC-1:0] dom_rst_n;
  logic [N_SRC-1:0] on_req;
  logic [N_SRC-1:0] en_vec;
  logic [N_SRC-1:0] gclk;

  assign src_clk = {pll_b_clk_i, pll_a_clk_i, main_clk_i, slow_clk_i};

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
      mcs_reset_sync #(.STAGES(RST_STAGES)) u_rst (
        .clk_i    (src_clk[i]),
        .arst_n_i (rst_n_i),
        .rst_n_o  (dom_rst_n[i])
      );
      mcs_gate_cell #(
        .SYNC_STAGES (SYNC_STAGES),
        .DIRECT      (i == int'(SRC_SLOW))
      ) u_gate (
        .src_clk_i (src_clk[i]),
        .rst_n_i   (dom_rst_n[i]),
        .on_req_i  (on_req[i]),
        .en_o      (en_vec[i]),
        .gclk_o    (gclk[i])
      );
    end
  endgenerate

  mcs_sequencer #(.ACK_STAGES(SYNC_STAGES)) u_seq (
    .clk_i     (slow_clk_i),
    .rst_n_i   (dom_rst_n[SRC_SLOW]),
    .sel_we_i  (sel_we_i),
    .sel_src_i (sel_src_i),
    .ack_raw_i (en_vec),
    .on_req_o  (on_req),
    .busy_o    (busy_o),
    .cur_src_o (cur_src_o)
  );

  assign mck_o = |gclk;

  // Enables come from separate clock domains; at most one may be set.
  always_comb begin
    if (rst_n_i) begin
      assert_one_enable_R9: assert ($onehot0(en_vec));
    end
  end
endmodule

// File: tb/mck_source_switch_tb_top.sv
`timescale 1ns/1ps
module mck_source_switch_tb_top;
  localparam real TS = 250.0;
  localparam real TM = 20.0;
  localparam real TA = 8.0;
  localparam real TB = 12.0;
  localparam real EPS = 0.05;

  logic rst_n, slow_clk, main_clk, pll_a_clk, pll_b_clk;
  logic sel_we;
  logic [1:0] sel_src;
  logic mck, busy;
  logic [1:0] cur_src;

  int n_chk = 0;
  int n_fail = 0;
  int rise_cnt = 0;
  int bad_hi = 0;
  int bad_lo = 0;
  bit mon_on = 0;
  bit have_rise = 0;
  bit have_fall = 0;
  real last_rise = 0.0;
  real last_fall = 0.0;
  int cur_model = 0;

  mck_source_switch dut_i (
    .rst_n_i     (rst_n),
    .slow_clk_i  (slow_clk),
    .main_clk_i  (main_clk),
    .pll_a_clk_i (pll_a_clk),
    .pll_b_clk_i (pll_b_clk),
    .sel_we_i    (sel_we),
    .sel_src_i   (sel_src),
    .mck_o       (mck),
    .busy_o      (busy),
    .cur_src_o   (cur_src)
  );

  initial begin main_clk = 0; forever #(TM/2) main_clk = ~main_clk; end
  initial begin slow_clk = 0; #3.1; forever #(TS/2) slow_clk = ~slow_clk; end
  initial begin pll_a_clk = 0; #1.3; forever #(TA/2) pll_a_clk = ~pll_a_clk; end
  initial begin pll_b_clk = 0; #0.7; forever #(TB/2) pll_b_clk = ~pll_b_clk; end

  function automatic real period_of(int s);
    case (s)
      0: return TS;
      1: return TM;
      2: return TA;
      default: return TB;
    endcase
  endfunction

  function automatic int exp_slow_cycles(int f, int t);
    if (f >= 2 && t >= 2) return 7;
    if (t == 0) return 5;
    if (t == 1) return (f >= 2) ? 4 : 3;
    return (f == 1) ? 5 : 4;
  endfunction

  function automatic string req_of(int f, int t);
    if (t == 0) return "R5/R9";
    if (f == 0) return "R6/R9";
    if (f >= 2 && t >= 2) return "R8/R9";
    return "R7/R9";
  endfunction

  function automatic bit is_half_period(real w);
    return (w > TS/2-EPS && w < TS/2+EPS) || (w > TM/2-EPS && w < TM/2+EPS) ||
           (w > TA/2-EPS && w < TA/2+EPS) || (w > TB/2-EPS && w < TB/2+EPS);
  endfunction

  // R10 phase monitors
  always @(posedge mck) begin
    rise_cnt++;
    if (mon_on && have_fall && ($realtime - last_fall) < TA/2 - EPS) bad_lo++;
    last_rise = $realtime;
    have_rise = 1;
  end
  always @(negedge mck) begin
    if (mon_on && have_rise && !is_half_period($realtime - last_rise)) bad_hi++;
    last_fall = $realtime;
    have_fall = 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  task automatic measure_period(input string req, input real exp);
    real ta, tb;
    @(posedge mck); ta = $realtime;
    @(posedge mck); tb = $realtime;
    chk((tb - ta) > exp - EPS && (tb - ta) < exp + EPS, req, "output period", tb - ta, exp);
  endtask

  task automatic do_switch(input int tgt, input int extra);
    real t0, t1, lo, hi, tn;
    int snap, n;
    int from = cur_model;
    @(negedge slow_clk); sel_we = 1; sel_src = 2'(tgt);
    @(posedge slow_clk); t0 = $realtime;
    @(negedge slow_clk); sel_we = 0;
    #1;
    snap = rise_cnt;
    chk(busy === 1'b1, "R2", "busy during switch", real'(busy), 1.0);
    if (extra >= 0) begin
      @(negedge slow_clk); sel_we = 1; sel_src = 2'(extra);
      @(negedge slow_clk); sel_we = 0;
    end
    wait (rise_cnt != snap);
    t1 = $realtime;
    n  = exp_slow_cycles(from, tgt);
    tn = period_of(tgt);
    if (tgt == 0) begin
      lo = t0 + n*TS; hi = lo;
    end else begin
      lo = t0 + n*TS + 2.0*tn; hi = t0 + n*TS + 3.0*tn;
    end
    chk(t1 >= lo - EPS && t1 <= hi + EPS, req_of(from, tgt),
        $sformatf("first new edge %0d->%0d (offset from accept)", from, tgt), t1 - t0, lo - t0);
    for (int i = 0; i < 12 && busy; i++) @(negedge slow_clk);
    chk(busy === 1'b0, "R2", "busy clears", real'(busy), 0.0);
    chk(cur_src == 2'(tgt), "R2", "current source code", real'(cur_src), real'(tgt));
    if (extra >= 0) begin
      repeat (2) @(negedge slow_clk);
      chk(busy === 1'b0 && cur_src == 2'(tgt), "R3", "write during busy ignored",
          real'(cur_src), real'(tgt));
    end
    measure_period("R11", tn);
    cur_model = tgt;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge main_clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int dir_seq [12] = '{1, 0, 2, 0, 3, 1, 2, 1, 3, 2, 3, 0};
    void'($urandom(32'h5A17));
    rst_n = 0; sel_we = 0; sel_src = 2'd0;
    #1003 rst_n = 1;
    repeat (4) @(negedge slow_clk);
    mon_on = 1;
    // R1 reset state
    chk(busy === 1'b0, "R1", "busy after reset", real'(busy), 0.0);
    chk(cur_src === 2'd0, "R1", "source after reset", real'(cur_src), 0.0);
    measure_period("R1", TS);

    // R4 write naming the current source
    @(negedge slow_clk); sel_we = 1; sel_src = 2'd0;
    @(negedge slow_clk); sel_we = 0;
    chk(busy === 1'b0, "R4", "same-source write busy", real'(busy), 0.0);
    measure_period("R4", TS);

    // every ordered pair, some with a stray write while busy
    for (int i = 0; i < 12; i++)
      do_switch(dir_seq[i], (i % 4 == 1) ? ((dir_seq[i] + 2) % 4) : -1);

    // R4 again on a fast source
    do_switch(2, -1);
    @(negedge slow_clk); sel_we = 1; sel_src = 2'd2;
    @(negedge slow_clk); sel_we = 0;
    chk(busy === 1'b0 && cur_src == 2'd2, "R4", "same-source write on PLL",
        real'(cur_src), 2.0);

    // random sequence
    for (int k = 0; k < 10; k++) begin
      int t = int'($urandom % 4);
      if (t == cur_model) t = (t + 1) % 4;
      do_switch(t, (k % 3 == 0) ? int'($urandom % 4) : -1);
    end

    chk(bad_hi == 0, "R10", "high phases not a half period", real'(bad_hi), 0.0);
    chk(bad_lo == 0, "R10", "short low phases", real'(bad_lo), 0.0);
    finish_run();
  end
endmodule